// File: doc/BRIEF.md
# Locking Round-Robin Bus Arbiter

This block decides which of several requesters owns a shared synchronous bus. Each requester has its own request input and its own grant output. At most one grant is high at any time, and the port that holds it is the only one allowed to drive the shared address/data lines. Arbitration is fully synchronous. Request and lock inputs are sampled on the rising clock edge, and grants change only on that edge.

The port that holds the grant can raise its lock input to keep ownership across several bus transactions. This makes a read-modify-write or a similar sequence atomic with respect to the other requesters. No timer limits how long a lock is held. The grant moves only after the holder has dropped both its request and its lock.

Each release is followed by one idle turnaround cycle, so that two drivers never overlap. The next owner is then chosen in round-robin order, starting from the port just above the previous holder. A lock raised by a port that does not hold the grant has no effect.

Top module: `lockArb`

## Requirements
- R1: While reset is asserted and right after it is released, every grant output is low and `busBusy` is low.
- R2: At most one bit of `grantOut` is high in any cycle.
- R3: When no port holds the grant and the arbiter is not in a turnaround cycle, a request sampled at a clock edge produces a grant on that same edge. The grant goes only to a port whose request was high.
- R4: While the granted port keeps its request high, the grant stays on that port, whatever the other ports request.
- R5: While the granted port keeps its lock high, the grant stays on that port even with its request low. There is no time limit on this.
- R6: A lock input from a port that does not hold the grant has no effect. It neither wins a grant nor holds the bus, and a port whose lock is high but whose request is low is never granted.
- R7: When the granted port has both its request and its lock low at a clock edge, all grants go low on that edge and `busBusy` stays high for exactly one turnaround cycle. A new grant can be given only at the edge that ends that cycle.
- R8: The winner of each arbitration is the first requesting port found by scanning upward from the previous holder plus one, wrapping from the highest port to port 0. After reset the scan starts at port 0.
- R9: With no requests pending and no grant held, no grant is issued and `busBusy` is low from the edge after the turnaround ends.
- R10: A holder that releases and then requests again during the turnaround cycle gets the grant back only if no other port above it in round-robin order is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_PORTS | Per-port bus request |
| lockIn | input | NUM_PORTS | Per-port lock; only the bit of the granted port is used |
| grantOut | output | NUM_PORTS | One-hot (or all-zero) bus grant |
| busBusy | output | 1 | High while a port holds the grant or during the turnaround cycle |

## Verification
Two events can land on the same edge. The holder can drop its lock just as another port raises both its lock and its request. Or a lock can appear on a waiting port while the holder still owns the bus. The bench provokes both with directed sequences and again with a long pseudo-random stretch of requests and locks. A reference model in the bench predicts the grant and busy state for every cycle. The result is judged by two checks: the non-holder's lock must not freeze anything, and the grant must vacate for exactly one cycle and then move to the round-robin winner, whose own lock then holds it.

// File: rtl/arbPkg.sv
package arbPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeGrant;   // capture the round-robin winner as new owner
    logic dropGrant;   // clear the grant register
  } arbStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OWNED = 2'd1,
    ST_TURN  = 2'd2
  } arbStateT;

endpackage

// File: rtl/arbPrioEnc.sv
// Lowest-index-first finder over a request vector.
module arbPrioEnc #(
  parameter int WIDTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic             found,
  output logic [IDX_W-1:0] idxOut
);

  always_comb begin
    found  = 1'b0;
    idxOut = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        found  = 1'b1;
        idxOut = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/arbCtrl.sv
// Ownership state machine: idle, owned, turnaround.
module arbCtrl
  import arbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyReq,
  input  logic      holdReq,
  output arbStrobeT strobe,
  output logic      busBusy
);

  arbStateT stateQ, stateD;

  always_comb begin
    stateD           = stateQ;
    strobe.takeGrant = 1'b0;
    strobe.dropGrant = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (anyReq) begin
          stateD           = ST_OWNED;
          strobe.takeGrant = 1'b1;
        end
      end
      ST_OWNED: begin
        // no timeout: only the holder letting go moves us on
        if (!holdReq) begin
          stateD           = ST_TURN;
          strobe.dropGrant = 1'b1;
        end
      end
      ST_TURN: begin
        if (anyReq) begin
          stateD           = ST_OWNED;
          strobe.takeGrant = 1'b1;
        end else begin
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busBusy = (stateQ != ST_IDLE);

endmodule

// File: rtl/arbDatapath.sv
// Grant register, round-robin pointer and winner selection.
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [NUM_PORTS-1:0] lockIn,
  input  arbStrobeT            strobe,
  output logic [NUM_PORTS-1:0] grantOut,
  output logic                 anyReq,
  output logic                 holdReq
);

  localparam logic [IDX_W-1:0] LAST_PORT = IDX_W'(NUM_PORTS - 1);

  logic [IDX_W-1:0]     lastIdx;
  logic [NUM_PORTS-1:0] grantQ, grantD;
  logic [NUM_PORTS-1:0] aboveMask, reqAbove, holdVec;
  logic                 hiFound, loFound;
  logic [IDX_W-1:0]     hiIdx, loIdx, pickIdx;

  // per-port masks: ports above the last owner, and holder's keep-alive
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign aboveMask[p] = (lastIdx < IDX_W'(p));
    assign holdVec[p]   = grantQ[p] & (reqIn[p] | lockIn[p]);
  end

  assign reqAbove = reqIn & aboveMask;

  arbPrioEnc #(.WIDTH(NUM_PORTS), .IDX_W(IDX_W)) u_hiEnc (
    .vecIn (reqAbove),
    .found (hiFound),
    .idxOut(hiIdx)
  );

  arbPrioEnc #(.WIDTH(NUM_PORTS), .IDX_W(IDX_W)) u_loEnc (
    .vecIn (reqIn),
    .found (loFound),
    .idxOut(loIdx)
  );

  assign pickIdx = hiFound ? hiIdx : loIdx;
  assign anyReq  = loFound;
  assign holdReq = |holdVec;

  always_comb begin
    grantD = grantQ;
    if (strobe.dropGrant) grantD = '0;
    if (strobe.takeGrant) begin
      grantD          = '0;
      grantD[pickIdx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ  <= '0;
      lastIdx <= LAST_PORT;
    end else begin
      grantQ <= grantD;
      if (strobe.takeGrant) lastIdx <= pickIdx;
    end
  end

  assign grantOut = grantQ;

endmodule

// File: rtl/lockArb.sv
// Top: locking round-robin bus arbiter.
module lockArb
  import arbPkg::*;
#(
  parameter int NUM_PORTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqIn,
  input  logic [NUM_PORTS-1:0] lockIn,
  output logic [NUM_PORTS-1:0] grantOut,
  output logic                 busBusy
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  arbStrobeT strobe;
  logic      anyReq, holdReq;

  arbCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyReq (anyReq),
    .holdReq(holdReq),
    .strobe (strobe),
    .busBusy(busBusy)
  );

  arbDatapath #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (reqIn),
    .lockIn  (lockIn),
    .strobe  (strobe),
    .grantOut(grantOut),
    .anyReq  (anyReq),
    .holdReq (holdReq)
  );

endmodule

// File: rtl/lockArbChecker.sv
module lockArbChecker #(
  parameter int NUM_PORTS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] reqIn,
  input logic [NUM_PORTS-1:0] lockIn,
  input logic [NUM_PORTS-1:0] grantOut,
  input logic                 busBusy
);

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut)); // R2

  AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (|(grantOut & (reqIn | lockIn))) |=> $stable(grantOut)); // R4 R5

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantOut) && !(|(grantOut & (reqIn | lockIn))))
      |=> (grantOut == '0 && busBusy)); // R7

  AST_NEW_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut == '0) |=> (grantOut == '0 || (|(grantOut & $past(reqIn))))); // R3

  AST_FOREIGN_LOCK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut == '0) |=> ((grantOut & $past(lockIn) & ~$past(reqIn)) == '0)); // R6

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && reqIn == '0) |=> (grantOut == '0 && !busBusy)); // R9

endmodule

bind lockArb lockArbChecker #(.NUM_PORTS(NUM_PORTS)) u_lockArbChecker (
  .clk     (clk),
  .rstN    (rstN),
  .reqIn   (reqIn),
  .lockIn  (lockIn),
  .grantOut(grantOut),
  .busBusy (busBusy)
);

// File: tb/lockArb_bench.sv
module lockArb_bench;

  localparam int  P          = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] reqIn = '0;
  logic [P-1:0] lockIn = '0;
  logic [P-1:0] grantOut;
  logic         busBusy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  lockArb #(.NUM_PORTS(P)) u_lockArb (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lockIn(lockIn),
    .grantOut(grantOut), .busBusy(busBusy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [P-1:0] grant;
    logic         busy;
    int           stamp;
    string        tag;
  } expT;
  expT expQ[$];

  // reference model state
  int mOwn  = -1;
  bit mTurn = 1'b0;
  int mLast = P - 1;

  function automatic int rrPick(input logic [P-1:0] r);
    for (int k = 1; k <= P; k++) begin
      if (r[(mLast + k) % P]) return (mLast + k) % P;
    end
    return -1;
  endfunction

  function automatic void modelStep(input logic [P-1:0] r, input logic [P-1:0] l);
    if (mOwn >= 0) begin
      if (!(r[mOwn] || l[mOwn])) begin
        mLast = mOwn;
        mOwn  = -1;
        mTurn = 1'b1;
      end
    end else begin
      mOwn  = rrPick(r);
      mTurn = 1'b0;
    end
  endfunction

  // driver: applies inputs and pushes the expected result of the next edge
  task automatic drive(input logic [P-1:0] r, input logic [P-1:0] l, input string tag);
    expT e;
    @(negedge clk);
    reqIn  = r;
    lockIn = l;
    modelStep(r, l);
    e.grant = (mOwn >= 0) ? (P'(1) << mOwn) : '0;
    e.busy  = (mOwn >= 0) || mTurn;
    e.stamp = cyc;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares one result per cycle, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].stamp < cyc) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (grantOut !== e.grant || busBusy !== e.busy) begin
        fails++;
        $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
                 e.tag, grantOut, busBusy, e.grant, e.busy);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    checks++;
    if (grantOut !== '0 || busBusy !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%b busy=%b expected grant=0 busy=0", grantOut, busBusy);
    end
    @(negedge clk) rstN = 1'b1;
    checks++;
    if (grantOut !== '0 || busBusy !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%b busy=%b expected grant=0 busy=0", grantOut, busBusy);
    end

    drive(8'h00, 8'h00, "R9");
    drive(8'h00, 8'h04, "R6");              // lock only, no grant: r6_
    drive(8'h00, 8'h04, "R6");
    drive(8'h08, 8'h00, "R3");              // port 3 wins from idle
    repeat (3) drive(8'h28, 8'h20, "R4");   // port 5 lock+req ignored
    repeat (300) drive(8'h20, 8'h08, "R5"); // holder locks with req low
    drive(8'h20, 8'h00, "R7");              // release -> turnaround
    drive(8'h22, 8'h00, "R8");              // scan from 4 -> port 5
    drive(8'h42, 8'h00, "R7");              // port 5 drops
    drive(8'h42, 8'h00, "R8");              // scan from 6 -> port 6
    drive(8'h03, 8'h00, "R7");
    drive(8'h03, 8'h00, "R8");              // wrap: 7,0 -> port 0
    // holder drops lock while waiting port raises lock and request together
    drive(8'h04, 8'h05, "R5");
    drive(8'h04, 8'h04, "R7");
    drive(8'h04, 8'h04, "R8");              // port 2
    repeat (5) drive(8'h00, 8'h04, "R5");
    drive(8'h00, 8'h00, "R7");
    drive(8'h00, 8'h00, "R9");
    drive(8'h00, 8'h00, "R9");
    // re-request during turnaround
    drive(8'h10, 8'h00, "R3");
    drive(8'h00, 8'h00, "R7");
    drive(8'h10, 8'h00, "R10");             // only requester: port 4 again
    drive(8'h00, 8'h00, "R7");
    drive(8'h11, 8'h00, "R10");             // port 0 after 4? scan 5..7,0 -> 0
    drive(8'h00, 8'h00, "R7");
    drive(8'h00, 8'h00, "R9");

    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[7:0], lf[15:8] & lf[7:0] & {P{lf[3]}}, "R2");
    end
    drive(8'h00, 8'h00, "R7");
    drive(8'h00, 8'h00, "R9");
    drive(8'h00, 8'h00, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule